// File: doc/BRIEF.md
# Bipolar Stepping Motor Pulse Generator

This block drives the two terminals of a bipolar stepping motor from a 32768 Hz timebase. Once per programmed output period it issues one drive pulse, and each pulse has the opposite polarity to the one before it. Between pulses both terminals are tied to the supply rail, so the winding is shorted and the rotor is damped. An 8-bit settings word sets the main pulse width, the output period, full or chopped drive, and an optional low-duty stretching tail that follows the main pulse.

There are two slow control inputs. A stop input halts stepping and opens every motor switch. After stop is released, stepping resumes exactly one full period later, and polarity continues from where it was. A test input shortens the period to 1/32 s for accelerated mechanical testing. Both inputs pass through a tick-based filter, so short glitches are ignored. The outputs are four switch enables (high-side and low-side for each terminal) and a flag that reports that the switches are open.

Top module: `mpg_motor_drive`

## Requirements
- R1: Successive pulses alternate polarity. Polarity 0 drives terminal A high and B low (`a_hi_o`=1, `b_lo_o`=1). Polarity 1 drives B high and A low. The first pulse after reset uses polarity 0.
- R2: Outside a pulse, and while not stopped, both high-side enables are 1 and both low-side enables are 0 (winding shorted to the rail).
- R3: `cfg_i[2:0]` = w sets the main pulse length tp = (w+1)·TP_UNIT clock cycles (TP_UNIT = 32 at 32768 Hz, about 0.98 ms per step).
- R4: `cfg_i[5:3]` selects the period in seconds (SEC_CYCLES clocks per second): 0→1, 1→5, 2→10, 3→20, 4→30, and 5–7→1. The first pulse starts exactly one period after reset is released, and later pulses repeat every period.
- R5: `cfg_i[6]`=1 drives every cycle of the main pulse. `cfg_i[6]`=0 chops it at 75%: within the pulse, a cycle whose index mod 4 equals 3 is shorted and the other cycles are driven.
- R6: `cfg_i[7]`=1 appends a tail of 2·tp cycles right after the main pulse, with the same polarity. Only tail cycles whose index mod 4 equals 0 are driven (25% duty).
- R7: While stop is accepted, `release_o`=1 and all four enables are 0, and any pulse in progress is abandoned. After `release_o` falls, the first pulse starts exactly one period later, with polarity opposite to the last pulse issued.
- R8: Stop and test are sampled every SEC_CYCLES/32 clocks. A level is accepted only after two consecutive samples agree, which gives an acceptance delay between one and two sample intervals. A pulse shorter than one interval is never accepted.
- R9: While test is accepted, pulses repeat every SEC_CYCLES/32 clocks (32 Hz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32768 Hz timebase |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_i | input | 8 | Settings word: width, period, full drive, stretch |
| stop_i | input | 1 | Stop request, level, unfiltered |
| test_i | input | 1 | Fast-step request, level, unfiltered |
| a_hi_o | output | 1 | Terminal A high-side switch enable |
| a_lo_o | output | 1 | Terminal A low-side switch enable |
| b_hi_o | output | 1 | Terminal B high-side switch enable |
| b_lo_o | output | 1 | Terminal B low-side switch enable |
| release_o | output | 1 | All motor switches open (stop accepted) |

## Verification
The bench measures the start cycle, driven-cycle count and span of the first pulse for every period code, including the unused codes 5–7. A design that mapped those codes to some other period, or that started its counter off by one, would place the pulse at the wrong cycle. Chopped and stretched shapes are counted cycle by cycle, so a tail with the wrong phase or length, or a chop with the wrong mod-4 slot, changes the driven count or the span. Around stop, the bench checks the debounce window from both sides, and it checks that the first pulse after release lands exactly one period after the release with flipped polarity. A design that reset polarity on stop, or resumed early, fails there. The bench also checks that a one-cycle stop glitch and the 32 Hz test rate behave as required.

// File: rtl/mpg_pkg.sv
package mpg_pkg;

    // Settings word, MSB first: stretch, full, period code, width code
    typedef struct packed {
        logic       stretch;
        logic       full;
        logic [2:0] period;
        logic [2:0] width;
    } mpg_cfg_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_MAIN = 2'd1,
        PH_TAIL = 2'd2
    } mpg_phase_e;

    // Period code to whole seconds; unused codes fall back to one second
    function automatic int unsigned period_secs(input logic [2:0] code);
        case (code)
            3'd1:    return 5;
            3'd2:    return 10;
            3'd3:    return 20;
            3'd4:    return 30;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/mpg_debounce.sv
module mpg_debounce (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw,
    output logic filt
);
    typedef struct packed {
        logic samp;
        logic filt;
    } deb_state_t;

    deb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            st_d.samp = raw;
            if (raw == st_q.samp) begin
                st_d.filt = raw;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign filt = st_q.filt;
endmodule

// File: rtl/mpg_period.sv
module mpg_period #(
    parameter int unsigned SEC_CYCLES = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt,
    input  logic       test,
    input  logic [2:0] per_code,
    output logic       fire
);
    import mpg_pkg::*;

    localparam int unsigned MAX_LEN  = 30 * SEC_CYCLES;
    localparam int unsigned TEST_LEN = SEC_CYCLES / 32;
    localparam int unsigned CNT_W    = $clog2(MAX_LEN + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } per_state_t;

    per_state_t        st_d, st_q;
    logic [CNT_W-1:0]  len;

    always_comb begin
        if (test) begin
            len = CNT_W'(TEST_LEN);
        end else begin
            len = CNT_W'(period_secs(per_code) * SEC_CYCLES);
        end
        fire = !halt && (st_q.cnt >= len - 1'b1);
        st_d = st_q;
        if (halt || fire) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/mpg_shaper.sv
module mpg_shaper #(
    parameter int unsigned TP_UNIT = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fire,
    input  logic       halt,
    input  logic [2:0] width,
    input  logic       full,
    input  logic       stretch,
    output logic       a_hi,
    output logic       a_lo,
    output logic       b_hi,
    output logic       b_lo,
    output logic       pol_next
);
    import mpg_pkg::*;

    localparam int unsigned CNT_W = $clog2(16 * TP_UNIT) + 1;

    typedef struct packed {
        mpg_phase_e       phase;
        logic [CNT_W-1:0] cnt;
        logic             cur_pol;
        logic             nxt_pol;
    } shp_state_t;

    shp_state_t        st_d, st_q;
    logic [CNT_W-1:0]  tp_len;
    logic [CNT_W-1:0]  tail_len;
    logic              drive;

    always_comb begin
        tp_len   = CNT_W'((int'(width) + 1) * TP_UNIT);
        tail_len = tp_len << 1;
        st_d     = st_q;
        if (halt) begin
            st_d.phase = PH_IDLE;
            st_d.cnt   = '0;
        end else if (fire) begin
            st_d.phase   = PH_MAIN;
            st_d.cnt     = '0;
            st_d.cur_pol = st_q.nxt_pol;
            st_d.nxt_pol = ~st_q.nxt_pol;
        end else begin
            case (st_q.phase)
                PH_MAIN: begin
                    if (st_q.cnt == tp_len - 1'b1) begin
                        st_d.cnt   = '0;
                        st_d.phase = stretch ? PH_TAIL : PH_IDLE;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                PH_TAIL: begin
                    if (st_q.cnt == tail_len - 1'b1) begin
                        st_d.cnt   = '0;
                        st_d.phase = PH_IDLE;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                default: begin
                    st_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, cur_pol: 1'b0, nxt_pol: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (st_q.phase)
            PH_MAIN: drive = full || (st_q.cnt[1:0] != 2'd3);
            PH_TAIL: drive = (st_q.cnt[1:0] == 2'd0);
            default: drive = 1'b0;
        endcase
        if (halt) begin
            {a_hi, a_lo, b_hi, b_lo} = 4'b0000;
        end else if (drive) begin
            a_hi = !st_q.cur_pol;
            b_lo = !st_q.cur_pol;
            b_hi = st_q.cur_pol;
            a_lo = st_q.cur_pol;
        end else begin
            {a_hi, a_lo, b_hi, b_lo} = 4'b1010;
        end
    end

    assign pol_next = st_q.nxt_pol;
endmodule

// File: rtl/mpg_motor_drive.sv
module mpg_motor_drive #(
    parameter int unsigned SEC_CYCLES = 32768,
    parameter int unsigned TP_UNIT    = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] cfg_i,
    input  logic       stop_i,
    input  logic       test_i,
    output logic       a_hi_o,
    output logic       a_lo_o,
    output logic       b_hi_o,
    output logic       b_lo_o,
    output logic       release_o
);
    import mpg_pkg::*;

    localparam int unsigned DEB_LEN = SEC_CYCLES / 32;
    localparam int unsigned DEB_W   = (DEB_LEN > 1) ? $clog2(DEB_LEN) : 1;
    localparam int unsigned N_CTL   = 2;

    typedef struct packed {
        logic [DEB_W-1:0] tick_cnt;
    } top_state_t;

    top_state_t        st_d, st_q;
    mpg_cfg_t          cfg;
    logic              tick_w;
    logic              fire_w;
    logic              halt_w;
    logic              test_w;
    logic              pol_next_w;
    logic [N_CTL-1:0]  ctl_raw;
    logic [N_CTL-1:0]  ctl_filt;

    assign cfg = mpg_cfg_t'(cfg_i);

    // Shared sampling tick for the control filters
    always_comb begin
        tick_w = (st_q.tick_cnt == DEB_W'(DEB_LEN - 1));
        st_d   = st_q;
        st_d.tick_cnt = tick_w ? '0 : st_q.tick_cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_raw = {test_i, stop_i};

    for (genvar g = 0; g < N_CTL; g++) begin : g_deb
        mpg_debounce u_deb (
            .clk  (clk),
            .rst_n(rst_n),
            .tick (tick_w),
            .raw  (ctl_raw[g]),
            .filt (ctl_filt[g])
        );
    end

    assign halt_w = ctl_filt[0];
    assign test_w = ctl_filt[1];

    mpg_period #(.SEC_CYCLES(SEC_CYCLES)) u_period (
        .clk     (clk),
        .rst_n   (rst_n),
        .halt    (halt_w),
        .test    (test_w),
        .per_code(cfg.period),
        .fire    (fire_w)
    );

    mpg_shaper #(.TP_UNIT(TP_UNIT)) u_shaper (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire_w),
        .halt    (halt_w),
        .width   (cfg.width),
        .full    (cfg.full),
        .stretch (cfg.stretch),
        .a_hi    (a_hi_o),
        .a_lo    (a_lo_o),
        .b_hi    (b_hi_o),
        .b_lo    (b_lo_o),
        .pol_next(pol_next_w)
    );

    assign release_o = halt_w;
endmodule

// File: rtl/mpg_checker.sv
module mpg_checker (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic fire,
    input logic halt,
    input logic pol_next,
    input logic a_hi,
    input logic a_lo,
    input logic b_hi,
    input logic b_lo,
    input logic release_o
);
    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_hi && a_lo) && !(b_hi && b_lo)); // R1

    AST_POL_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (pol_next != $past(pol_next))); // R1

    AST_IDLE_SHORTED: assert property (@(posedge clk) disable iff (!rst_n)
        (!release_o && !a_lo && !b_lo) |-> (a_hi && b_hi)); // R2

    AST_STOP_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |-> (!a_hi && !a_lo && !b_hi && !b_lo)); // R7

    AST_STOP_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !fire); // R7

    AST_FILTER_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(release_o)); // R8
endmodule

bind mpg_motor_drive mpg_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_w),
    .fire     (fire_w),
    .halt     (halt_w),
    .pol_next (pol_next_w),
    .a_hi     (a_hi_o),
    .a_lo     (a_lo_o),
    .b_hi     (b_hi_o),
    .b_lo     (b_lo_o),
    .release_o(release_o)
);

// File: tb/tb_mpg_motor_drive.sv
`timescale 1ns/1ps
module tb_mpg_motor_drive;
    localparam int SEC  = 1024;
    localparam int TPU  = 4;
    localparam int TICK = SEC / 32;
    localparam int NV   = 8;

    // cfg, period cycles, driven cycles, span of first pulse
    localparam int V_CFG [NV] = '{8'h40, 8'h47, 8'h0B, 8'hD1, 8'h9A, 8'h60, 8'h68, 8'h78};
    localparam int V_PER [NV] = '{1024, 1024, 5120, 10240, 20480, 30720, 1024, 1024};
    localparam int V_ON  [NV] = '{4, 32, 12, 12, 15, 4, 4, 4};
    localparam int V_SPAN[NV] = '{4, 32, 15, 21, 33, 4, 4, 4};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg = 8'h40;
    logic       stop = 1'b0;
    logic       test = 1'b0;
    logic       a_hi, a_lo, b_hi, b_lo, rel;

    int n_chk = 0;
    int n_fail = 0;
    int n = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mpg_motor_drive #(.SEC_CYCLES(SEC), .TP_UNIT(TPU)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .stop_i(stop), .test_i(test),
        .a_hi_o(a_hi), .a_lo_o(a_lo), .b_hi_o(b_hi), .b_lo_o(b_lo), .release_o(rel)
    );

    function automatic logic drv_a();  return a_hi && b_lo && !a_lo && !b_hi; endfunction
    function automatic logic drv_b();  return b_hi && a_lo && !a_hi && !b_lo; endfunction
    function automatic logic idle_ok(); return a_hi && b_hi && !a_lo && !b_lo && !rel; endfunction

    task automatic chk(input string req, input logic ok, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        n++;
    endtask

    task automatic do_reset(input logic [7:0] c);
        rst_n = 1'b0; cfg = c; stop = 1'b0; test = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n = 0;
    endtask

    initial begin
        int first, last, on, m, n0, s1, s2;
        logic pa, prev;

        // Reset state: shorted winding, switches closed (R2)
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R2 reset idle", idle_ok(), {a_hi, a_lo, b_hi, b_lo}, 4'b1010);

        // Table walk: shape and timing of the first pulse (R3 R4 R5 R6)
        for (int i = 0; i < NV; i++) begin
            do_reset(8'(V_CFG[i]));
            first = -1; last = -1; on = 0; pa = 1'b0;
            while (n < V_PER[i] + V_SPAN[i] + 4) begin
                step();
                if (n == V_PER[i] - 1)
                    chk("R2 idle before pulse", idle_ok(), {a_hi, a_lo, b_hi, b_lo}, 4'b1010);
                if (drv_a() || drv_b()) begin
                    if (first < 0) begin
                        first = n;
                        pa = drv_a();
                    end
                    last = n;
                    on++;
                end
            end
            chk("R4 first pulse start", first == V_PER[i], first, V_PER[i]);
            chk("R3/R5/R6 driven cycles", on == V_ON[i], on, V_ON[i]);
            chk("R3/R5/R6 pulse span", (last - first + 1) == V_SPAN[i], last - first + 1, V_SPAN[i]);
            chk("R1 first polarity A", pa, pa, 1);
        end

        // Alternation, stop, resume (R1 R7 R8)
        do_reset(8'h40);
        while (n < 1024) step();
        chk("R1 pulse 1 polarity A", drv_a(), {a_hi, a_lo, b_hi, b_lo}, 4'b1001);
        while (n < 2048) step();
        chk("R1 pulse 2 polarity B", drv_b(), {a_hi, a_lo, b_hi, b_lo}, 4'b0110);
        while (n < 2060) step();
        stop = 1'b1; n0 = n;
        while (n < n0 + TICK) step();
        chk("R8 stop not yet accepted", !rel, rel, 0);
        while (n < n0 + 2 * TICK + 2) step();
        chk("R7 stop opens switches", rel && !a_hi && !a_lo && !b_hi && !b_lo,
            {rel, a_hi, a_lo, b_hi, b_lo}, 5'b10000);
        while (n < n0 + 100) step();
        stop = 1'b0; n0 = n;
        while (rel && n < n0 + 4 * TICK) step();
        m = n;
        chk("R8 release delay window", (m > n0 + TICK) && (m <= n0 + 2 * TICK + 1), m - n0, TICK + 1);
        while (n < m + 1024 - 1) step();
        chk("R7 no pulse before one period", idle_ok(), {a_hi, a_lo, b_hi, b_lo}, 4'b1010);
        step();
        chk("R7 resume polarity A after B", drv_a(), {a_hi, a_lo, b_hi, b_lo}, 4'b1001);

        // One-cycle stop glitch is ignored (R8)
        while (n < m + 1200) step();
        stop = 1'b1;
        step();
        stop = 1'b0;
        on = 0;
        repeat (3 * TICK) begin
            step();
            if (rel) on++;
        end
        chk("R8 glitch ignored", on == 0, on, 0);

        // Test mode steps at 32 Hz (R9)
        test = 1'b1;
        repeat (3 * TICK + 40) step();
        s1 = -1; s2 = -1; prev = drv_a() || drv_b();
        while (s2 < 0 && n < m + 1600) begin
            step();
            if ((drv_a() || drv_b()) && !prev) begin
                if (s1 < 0) s1 = n; else s2 = n;
            end
            prev = drv_a() || drv_b();
        end
        chk("R9 test period", (s2 - s1) == TICK, s2 - s1, TICK);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R4 actual=%0d expected=%0d", n, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule